// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block connects a synchronous on-chip request port to an external 16-bit asynchronous static RAM with an 18-bit word address. It drives the RAM's active-low chip select, write strobe, output enable and two byte-lane enables. Every minimum timing interval is expressed as a whole number of system clock cycles, so each setup, pulse and access window is met by construction. The default values assume a 100 MHz clock.

A request carries a read/write flag, a word address, write data and a two-bit lane mask, and it is accepted on a valid/ready handshake. Writes are timed by the write strobe. Output enable stays high for the whole write, and the controller waits a turn-off interval after the strobe falls before it drives the bidirectional bus. The bus is released on the same edge at which the strobe rises. A read keeps chip select and output enable low for the access time, samples the bus, and returns the word with a one-cycle valid pulse. A turnaround interval then follows before the next access can start.

The data bus is presented as a separate output value, a drive-enable and an input value, so the pad tristate sits outside this block.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, chip select, write strobe and output enable are high (inactive), the bus drive-enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: When a write is accepted, the next T_ASU cycles have chip select low, write strobe high and output enable high. The write strobe is then low for T_OFF + T_WP cycles, and output enable stays high for the whole write.
- R3: The controller drives the bus only after the first T_OFF cycles of the write-strobe-low window, with `ram_dq_out` equal to the request's write data. It stops driving on the same edge at which the write strobe rises. It never drives while output enable is low.
- R4: Mask bit 0 selects lane enable `ram_be_n[0]` (bits 7:0), and mask bit 1 selects `ram_be_n[1]` (bits 15:8). Only the enables of selected lanes go low during an access, so an unselected lane keeps its stored byte.
- R5: A read holds chip select and output enable low with the write strobe high for T_RD cycles. The bus is then sampled. `rsp_valid` is high for exactly one cycle, the cycle after the last access cycle. Bits of unselected lanes read back as zero.
- R6: After a read, output enable and chip select stay high for at least T_TA cycles with `req_ready` low before any further access. The bus is never driven in the cycle after output enable was low.
- R7: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the access sequence, including any turnaround, has finished.
- R8: A request whose mask is zero never lowers the write strobe, output enable or chip select. As a read, it returns one `rsp_valid` pulse with zero data in the cycle after acceptance. As a write, it leaves memory unchanged.
- R9: Chip select is high in every cycle in which the controller is idle and ready.
- R10: While chip select is low, the address and lane enables do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, zero in unselected lanes |
| ram_addr | output | 18 | RAM word address |
| ram_ce_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_be_n | output | 2 | RAM lane enables, active low |
| ram_dq_out | output | 16 | Value driven onto the data bus |
| ram_dq_oe | output | 1 | Bus drive-enable, high = controller drives |
| ram_dq_in | input | 16 | Value read from the data bus |

## Verification
The hardest situation to reach is a write that begins soon after a read. This is where output-enable turn-off and the start of bus drive could overlap. The stimulus issues a read and then a write at the first cycle in which ready returns. A monitor checks that, in every cycle, the bus is never driven while output enable is low or in the cycle after it was low. The bench's RAM model puts a filler pattern on lanes that are not enabled, so a wrong lane mapping or missing masking shows up as a data miscompare. A reset asserted in the middle of a write checks that all strobes return to inactive at once.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WSET,
      ST_WOFF,
      ST_WDRV,
      ST_RACC,
      ST_TURN,
      ST_NULL
   } asram_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load)            cnt_q <= load_val;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_lane.sv
module asram_lane #(
   parameter int LW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          active,
   input  logic [LW-1:0] wbyte,
   input  logic [LW-1:0] rbyte_in,
   input  logic          clr,
   input  logic          cap,
   output logic          be_n,
   output logic [LW-1:0] dq_byte,
   output logic [LW-1:0] rbyte_q
);
   assign be_n    = !(active && sel);
   assign dq_byte = wbyte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rbyte_q <= '0;
      else if (clr)  rbyte_q <= '0;
      else if (cap)  rbyte_q <= sel ? rbyte_in : '0;
   end
endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int LANES = 2,
   parameter int T_ASU = 1,
   parameter int T_OFF = 1,
   parameter int T_WP  = 1,
   parameter int T_RD  = 2,
   parameter int T_TA  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [LANES-1:0] req_mask,
   output logic             req_ready,
   output logic             accept,
   output logic             rd_cap,
   output logic             rsp_valid,
   output logic             ce_n,
   output logic             we_n,
   output logic             oe_n,
   output logic             dq_oe
);
   localparam int T_MAX = imax(imax(T_ASU, T_OFF), imax(imax(T_WP, T_RD), T_TA));
   localparam int CW    = $clog2(T_MAX) + 1;

   asram_state_e state_q, nxt;
   logic          tload, tdone;
   logic [CW-1:0] tval;

   asram_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tload), .load_val(tval), .done(tdone)
   );

   assign accept = req_valid && req_ready;

   always_comb begin
      nxt    = state_q;
      tload  = 1'b0;
      tval   = '0;
      rd_cap = 1'b0;
      unique case (state_q)
         ST_IDLE: if (accept) begin
            tload = 1'b1;
            if (req_mask == '0)  nxt = ST_NULL;
            else if (req_write) begin nxt = ST_WSET; tval = CW'(T_ASU - 1); end
            else                 begin nxt = ST_RACC; tval = CW'(T_RD - 1);  end
         end
         ST_WSET: if (tdone) begin nxt = ST_WOFF; tload = 1'b1; tval = CW'(T_OFF - 1); end
         ST_WOFF: if (tdone) begin nxt = ST_WDRV; tload = 1'b1; tval = CW'(T_WP - 1);  end
         ST_WDRV: if (tdone) nxt = ST_IDLE;
         ST_RACC: if (tdone) begin
            nxt = ST_TURN; tload = 1'b1; tval = CW'(T_TA - 1); rd_cap = 1'b1;
         end
         ST_TURN: if (tdone) nxt = ST_IDLE;
         ST_NULL: nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   // strobes are registered from the next state so the pads see flop outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         req_ready <= 1'b1;
         rsp_valid <= 1'b0;
         ce_n      <= 1'b1;
         we_n      <= 1'b1;
         oe_n      <= 1'b1;
         dq_oe     <= 1'b0;
      end else begin
         state_q   <= nxt;
         req_ready <= (nxt == ST_IDLE);
         rsp_valid <= rd_cap || (accept && !req_write && req_mask == '0);
         ce_n      <= !(nxt inside {ST_WSET, ST_WOFF, ST_WDRV, ST_RACC});
         we_n      <= !(nxt inside {ST_WOFF, ST_WDRV});
         oe_n      <= !(nxt == ST_RACC);
         dq_oe     <= (nxt == ST_WDRV);
      end
   end

   a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int LANE_W = 8,
   parameter int LANES  = 2,
   parameter int T_ASU  = 1,
   parameter int T_OFF  = 1,
   parameter int T_WP   = 1,
   parameter int T_RD   = 2,
   parameter int T_TA   = 1,
   localparam int DATA_W = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_mask,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ram_ce_n,
   output logic              ram_we_n,
   output logic              ram_oe_n,
   output logic [LANES-1:0]  ram_be_n,
   output logic [DATA_W-1:0] ram_dq_out,
   output logic              ram_dq_oe,
   input  logic [DATA_W-1:0] ram_dq_in
);
   generate
      if (LANES < 1 || LANE_W < 1) begin : g_bad_shape
         $error("asram_ctrl: LANES and LANE_W must be positive");
      end
      if (T_ASU < 1 || T_OFF < 1 || T_WP < 1 || T_RD < 1 || T_TA < 1) begin : g_bad_timing
         $error("asram_ctrl: every timing parameter must be at least one cycle");
      end
   endgenerate

   logic              accept, rd_cap;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  mask_q;

   asram_seq #(
      .LANES(LANES), .T_ASU(T_ASU), .T_OFF(T_OFF), .T_WP(T_WP),
      .T_RD(T_RD), .T_TA(T_TA)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_mask(req_mask), .req_ready(req_ready), .accept(accept),
      .rd_cap(rd_cap), .rsp_valid(rsp_valid), .ce_n(ram_ce_n),
      .we_n(ram_we_n), .oe_n(ram_oe_n), .dq_oe(ram_dq_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         mask_q  <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         mask_q  <= req_mask;
      end
   end

   assign ram_addr = addr_q;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      asram_lane #(.LW(LANE_W)) u_lane (
         .clk(clk), .rst_n(rst_n), .sel(mask_q[i]), .active(!ram_ce_n),
         .wbyte(wdata_q[i*LANE_W +: LANE_W]),
         .rbyte_in(ram_dq_in[i*LANE_W +: LANE_W]),
         .clr(accept), .cap(rd_cap),
         .be_n(ram_be_n[i]),
         .dq_byte(ram_dq_out[i*LANE_W +: LANE_W]),
         .rbyte_q(rsp_rdata[i*LANE_W +: LANE_W])
      );
   end

   a_r3_no_drive_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
      ram_dq_oe |-> (ram_oe_n && !ram_we_n));
   a_r3_turnoff_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_we_n && $past(ram_we_n)) |-> !ram_dq_oe);
   a_r3_release_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we_n && $past(!ram_we_n)) |-> !ram_dq_oe);
   a_r6_oe_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!ram_oe_n) |-> !ram_dq_oe);
   a_r4_lane_selected: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> (ram_be_n != '1));
   a_r9_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> ram_ce_n);
   a_r10_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_ce_n && $past(!ram_ce_n)) |-> ($stable(ram_addr) && $stable(ram_be_n)));
endmodule

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [17:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_mask = '0;
   logic        req_ready, rsp_valid;
   logic [15:0] rsp_rdata, ram_dq_out, ram_dq_in;
   logic [17:0] ram_addr;
   logic        ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe;
   logic [1:0]  ram_be_n;

   int checks = 0, fails = 0;
   int rsp_cnt = 0, we_low = 0, oe_low = 0, ce_low = 0;
   logic [15:0] last_rdata = '0;
   logic [15:0] mem [16];
   logic prev_oe_low = 1'b0, prev_we_n = 1'b1, prev_ce_low = 1'b0;
   logic [17:0] prev_addr = '0;
   logic [1:0]  prev_be = '1;

   always #(CLK_P/2) clk = ~clk;

   asram_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n),
      .ram_oe_n(ram_oe_n), .ram_be_n(ram_be_n), .ram_dq_out(ram_dq_out),
      .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
   );

   function automatic int midx(input logic [17:0] a);
      return int'({a[17], a[2:0]});
   endfunction

   // RAM model: filler A5 on lanes that are not enabled
   always_comb begin
      ram_dq_in = 16'hA5A5;
      if (!ram_ce_n && !ram_oe_n && ram_we_n) begin
         if (!ram_be_n[0]) ram_dq_in[7:0]  = mem[midx(ram_addr)][7:0];
         if (!ram_be_n[1]) ram_dq_in[15:8] = mem[midx(ram_addr)][15:8];
      end
   end

   always @(posedge clk) begin
      if (rst_n && !ram_ce_n && !ram_we_n && ram_dq_oe) begin
         if (!ram_be_n[0]) mem[midx(ram_addr)][7:0]  <= ram_dq_out[7:0];
         if (!ram_be_n[1]) mem[midx(ram_addr)][15:8] <= ram_dq_out[15:8];
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // cycle monitor, sampled on the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (ram_dq_oe && !ram_oe_n)  check(0, "R3 drive while output enabled", 1, 0);
         if (ram_dq_oe && prev_oe_low) check(0, "R6 drive right after output enable", 1, 0);
         if (ram_dq_oe && prev_we_n)  check(0, "R3 drive without turn-off cycle", 1, 0);
         if (req_ready && !ram_ce_n)  check(0, "R9 chip select low while idle", 0, 1);
         if (prev_ce_low && !ram_ce_n && (ram_addr != prev_addr || ram_be_n != prev_be))
            check(0, "R10 address or lanes moved", {14'd0, ram_addr}, {14'd0, prev_addr});
         if (rsp_valid) begin rsp_cnt++; last_rdata = rsp_rdata; end
         if (!ram_we_n) we_low++;
         if (!ram_oe_n) oe_low++;
         if (!ram_ce_n) ce_low++;
      end
      prev_oe_low = rst_n && !ram_oe_n;
      prev_we_n   = ram_we_n;
      prev_ce_low = rst_n && !ram_ce_n;
      prev_addr   = ram_addr;
      prev_be     = ram_be_n;
   end

   task automatic do_req(input bit wr, input logic [1:0] m, input logic [17:0] a,
                         input logic [15:0] d, output logic [15:0] got, output int pulses);
      int r0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      r0 = rsp_cnt;
      req_valid = 1'b1; req_write = wr; req_mask = m; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 20 && !req_ready; k++) @(negedge clk);
      got = last_rdata;
      pulses = rsp_cnt - r0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   // {write, mask, addr, wdata, expected read}
   localparam int NV = 14;
   localparam logic [52:0] VEC [NV] = '{
      {1'b1, 2'b11, 18'h00005, 16'hA1B2, 16'h0000},
      {1'b0, 2'b11, 18'h00005, 16'h0000, 16'hA1B2},
      {1'b1, 2'b01, 18'h00005, 16'h33CC, 16'h0000},
      {1'b0, 2'b11, 18'h00005, 16'h0000, 16'hA1CC},
      {1'b1, 2'b10, 18'h00005, 16'h7700, 16'h0000},
      {1'b0, 2'b10, 18'h00005, 16'h0000, 16'h7700},
      {1'b0, 2'b01, 18'h00005, 16'h0000, 16'h00CC},
      {1'b1, 2'b11, 18'h3FFFF, 16'hFFFF, 16'h0000},
      {1'b0, 2'b11, 18'h3FFFF, 16'h0000, 16'hFFFF},
      {1'b1, 2'b00, 18'h00005, 16'h0000, 16'h0000},
      {1'b0, 2'b11, 18'h00005, 16'h0000, 16'h77CC},
      {1'b0, 2'b00, 18'h00005, 16'h0000, 16'h0000},
      {1'b1, 2'b11, 18'h00000, 16'h1234, 16'h0000},
      {1'b0, 2'b11, 18'h00000, 16'h0000, 16'h1234}
   };

   initial begin
      #(CLK_P * 200000);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [15:0] got;
      int pulses, w0, o0, c0;
      for (int i = 0; i < 16; i++) mem[i] = '0;

      // R1: reset state
      #(CLK_P * 3 + 2);
      check(ram_ce_n && ram_we_n && ram_oe_n && !ram_dq_oe && req_ready && !rsp_valid,
            "R1 reset state", {ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe, req_ready, rsp_valid}, 6'b111010);
      rst_n = 1'b1;
      @(negedge clk);
      check(ram_ce_n && req_ready && !ram_dq_oe, "R1 after release", {ram_ce_n, req_ready}, 2'b11);

      // vector table: R4 lanes, R5 reads, R8 null mask
      for (int v = 0; v < NV; v++) begin
         w0 = we_low; o0 = oe_low; c0 = ce_low;
         do_req(VEC[v][52], VEC[v][51:50], VEC[v][49:32], VEC[v][31:16], got, pulses);
         if (!VEC[v][52]) begin
            check(pulses == 1, "R5 one valid pulse per read", pulses, 1);
            check(got == VEC[v][15:0], "R4/R5 read data", got, VEC[v][15:0]);
         end else
            check(pulses == 0, "R7 no response for write", pulses, 0);
         if (VEC[v][51:50] == 2'b00)
            check(we_low == w0 && oe_low == o0 && ce_low == c0, "R8 null mask strobes idle",
                  we_low + oe_low + ce_low, w0 + o0 + c0);
      end

      // R2/R3 write timing, cycle by cycle
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_mask = 2'b11; req_addr = 18'h0002A; req_wdata = 16'h5A5A;
      @(negedge clk); req_valid = 1'b0;
      check(!ram_ce_n && ram_we_n && ram_oe_n && !ram_dq_oe && !req_ready && ram_addr == 18'h2A && ram_be_n == 2'b00,
            "R2 address setup cycle", {ram_ce_n, ram_we_n, ram_dq_oe, req_ready}, 4'b0100);
      @(negedge clk);
      check(!ram_we_n && !ram_dq_oe && ram_oe_n, "R3 turn-off cycle", {ram_we_n, ram_dq_oe}, 2'b00);
      @(negedge clk);
      check(!ram_we_n && ram_dq_oe && ram_dq_out == 16'h5A5A && ram_oe_n, "R3 drive cycle", ram_dq_out, 16'h5A5A);
      @(negedge clk);
      check(ram_we_n && !ram_dq_oe && ram_ce_n && req_ready, "R3/R9 release with strobe rise",
            {ram_we_n, ram_dq_oe, ram_ce_n, req_ready}, 4'b1011);

      // R5/R6 read timing, then a write right away
      req_valid = 1'b1; req_write = 1'b0; req_mask = 2'b11; req_addr = 18'h0002A;
      @(negedge clk); req_valid = 1'b0;
      check(!ram_ce_n && !ram_oe_n && ram_we_n && !rsp_valid, "R5 access cycle 1", {ram_oe_n, rsp_valid}, 2'b00);
      @(negedge clk);
      check(!ram_oe_n && !rsp_valid, "R5 access cycle 2", {ram_oe_n, rsp_valid}, 2'b00);
      @(negedge clk);
      check(rsp_valid && rsp_rdata == 16'h5A5A, "R5 response", rsp_rdata, 16'h5A5A);
      check(ram_oe_n && ram_ce_n && !req_ready, "R6 turnaround", {ram_oe_n, ram_ce_n, req_ready}, 3'b110);
      do_req(1'b1, 2'b10, 18'h0002A, 16'hC300, got, pulses);
      do_req(1'b0, 2'b11, 18'h0002A, 16'h0000, got, pulses);
      check(got == 16'hC35A, "R4 upper lane after read", got, 16'hC35A);

      // R1: reset in the middle of a write
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_mask = 2'b11; req_addr = 18'h00003; req_wdata = 16'hDEAD;
      @(negedge clk); req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b0; #1;
      check(ram_ce_n && ram_we_n && ram_oe_n && !ram_dq_oe && req_ready, "R1 reset mid-write",
            {ram_ce_n, ram_we_n, ram_dq_oe, req_ready}, 4'b1101);
      @(negedge clk); rst_n = 1'b1;
      do_req(1'b0, 2'b11, 18'h00003, 16'h0000, got, pulses);
      check(got == 16'h0000, "R3 aborted write not stored", got, 16'h0000);

      check(fails == 0, "R10 monitor clean", fails, 0);
      finish_run();
   end
endmodule